// File: doc/BRIEF.md
# Token-Addressed Fixed Delay Line

This block delays a stream of data words by a fixed number of accepted transfers. It stores the words in a small register file. A single circulating one-hot token addresses that file in place of a binary pointer and address decoder. In each accepted transfer, the token selects one word, and that word is copied to a registered output. In the same transfer, the incoming word is stored into the slot the token selected one transfer earlier. Each slot is therefore read just before it is overwritten, and data comes out after a full lap of the ring.

The words are split into equal groups. Each group has its own local enable, and the enable of a group is derived from the token alone. A group's enable rises one transfer before the token enters the group. It falls only after the token has left the group and the trailing store into the group's last slot has been made. In any transfer, at most two slots are touched and at most two groups are enabled. The depth, the word width and the group count are parameters, and the group count must divide the depth.

The input is a valid/ready interface. There is no back-pressure in normal operation: `in_ready` is high whenever reset is low. A transfer (a "step") takes place on a rising edge where `in_valid` and `in_ready` are both high. The output side cannot stall. `out_valid` pulses for one cycle after each step, while `out_data` holds the word read in that step until the next step.

Top module: `tdl_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_data` is 0 and `out_valid` is 0.
- R2: `out_valid` is 1 in the cycle after a step and 0 in the cycle after any rising edge without a step.
- R3: Number the steps since reset from 0. After step k, where k >= DEPTH-1, `out_data` equals the `in_data` accepted at step k-(DEPTH-1).
- R4: On a cycle without a step, the token, the group enables and the stored words all hold, and `out_data` keeps its value.
- R5: Exactly one token bit is set in every cycle after reset, and the reset position of the token is slot 0.
- R6: At most two group enables are high at once. The group holding the token and the group holding the slot to be written are always enabled, including across group boundaries.
- R7: The latency of R3 holds unchanged over many consecutive laps of the ring.
- R8: `in_data` presented while `in_valid` is low has no effect on any later output word.
- R9: `in_ready` is 0 while `rst` is high and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block accepts a word (high outside reset) |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | One-cycle pulse after each step |
| out_data | output | DATA_W | Delayed word, held between steps |

## Verification
Two things can land in the same step: a read from the first slot of one group, and the trailing store into the last slot of the group before it. In that step, both group enables must be live at once. The bench provokes this in two ways. It streams continuously across every group boundary. It also parks the stream with idle cycles on the exact steps before and after each boundary. In those idle cycles it feeds in junk data, and the handoff between the two enables has to survive the pause. The result is judged at the ports. Each output word is compared with a queue of accepted inputs, shifted by DEPTH-1 steps, so a lost boundary store or a stale read appears as a mismatch one lap later.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  // wrap an index onto a ring of n positions
  function automatic int ring_wrap(input int i, input int n);
    return ((i % n) + n) % n;
  endfunction
endpackage

// File: rtl/tdl_ring.sv
module tdl_ring #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [DEPTH-1:0] rd_tok,
  output logic [DEPTH-1:0] wr_tok
);
  import tdl_pkg::*;

  logic [DEPTH-1:0] tok_q;

  always_ff @(posedge clk) begin
    if (rst) tok_q <= DEPTH'(1);
    else if (adv) tok_q <= {tok_q[DEPTH-2:0], tok_q[DEPTH-1]};
  end

  assign rd_tok = tok_q;

  // slot i is written when the token sits one place past it
  for (genvar i = 0; i < DEPTH; i++) begin : g_wr
    assign wr_tok[i] = tok_q[ring_wrap(i + 1, DEPTH)];
  end

  assert_token_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(tok_q) == 1);
  assert_token_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(tok_q));
endmodule

// File: rtl/tdl_grp_en.sv
module tdl_grp_en #(
  parameter int DEPTH = 16,
  parameter int NGRP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [DEPTH-1:0] rd_tok,
  input  logic [DEPTH-1:0] wr_tok,
  output logic [NGRP-1:0]  grp_en
);
  import tdl_pkg::*;
  localparam int GW = DEPTH / NGRP;

  if (NGRP == 1) begin : g_single
    assign grp_en = 1'b1;
  end else begin : g_multi
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int SET_IDX = ring_wrap(g * GW - 1, DEPTH);
      localparam int CLR_IDX = ring_wrap((g + 1) * GW, DEPTH);
      logic en_q;
      // set-hold-clear element: set wins over clear
      always_ff @(posedge clk) begin
        if (rst) en_q <= (g == 0) || (g == NGRP - 1);
        else if (adv && rd_tok[SET_IDX]) en_q <= 1'b1;
        else if (adv && rd_tok[CLR_IDX]) en_q <= 1'b0;
      end
      assign grp_en[g] = en_q;
    end
  end

  logic [NGRP-1:0] rd_in_grp, wr_in_grp;
  for (genvar g = 0; g < NGRP; g++) begin : g_occ
    assign rd_in_grp[g] = |rd_tok[g*GW +: GW];
    assign wr_in_grp[g] = |wr_tok[g*GW +: GW];
  end

  assert_read_grp_enabled_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_in_grp & grp_en) != '0);
  assert_write_grp_enabled_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_in_grp & grp_en) != '0);
  assert_at_most_two_grps_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(grp_en) <= 2);
  assert_enable_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(grp_en));
endmodule

// File: rtl/tdl_bank.sv
module tdl_bank #(
  parameter int DATA_W = 8,
  parameter int GW     = 4
) (
  input  logic              clk,
  input  logic              en,
  input  logic              adv,
  input  logic [GW-1:0]     rd_sel,
  input  logic [GW-1:0]     wr_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [GW];
  logic [GW-1:0]     we;

  for (genvar i = 0; i < GW; i++) begin : g_word
    assign we[i] = adv & en & wr_sel[i];
    always_ff @(posedge clk) begin
      if (we[i]) word_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < GW; i++)
      if (rd_sel[i] && en) rdata = rdata | word_q[i];
  end

  assert_one_write_R4: assert property (@(posedge clk)
    $countones(we) <= 1);
endmodule

// File: rtl/tdl_top.sv
module tdl_top #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int NGRP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int GW = DEPTH / NGRP;

  logic              step;
  logic [DEPTH-1:0]  rd_tok, wr_tok;
  logic [NGRP-1:0]   grp_en;
  logic [DATA_W-1:0] grp_rd [NGRP];
  logic [DATA_W-1:0] rd_word;
  logic              ov_q;
  logic [DATA_W-1:0] od_q;

  assign in_ready = ~rst;
  assign step     = in_valid & in_ready;

  tdl_ring #(.DEPTH(DEPTH)) ring_i (
    .clk(clk), .rst(rst), .adv(step), .rd_tok(rd_tok), .wr_tok(wr_tok)
  );

  tdl_grp_en #(.DEPTH(DEPTH), .NGRP(NGRP)) gen_i (
    .clk(clk), .rst(rst), .adv(step), .rd_tok(rd_tok), .wr_tok(wr_tok),
    .grp_en(grp_en)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_bank
    tdl_bank #(.DATA_W(DATA_W), .GW(GW)) bank_i (
      .clk(clk), .en(grp_en[g]), .adv(step),
      .rd_sel(rd_tok[g*GW +: GW]), .wr_sel(wr_tok[g*GW +: GW]),
      .wdata(in_data), .rdata(grp_rd[g])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NGRP; g++) rd_word = rd_word | grp_rd[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= step;
      if (step) od_q <= rd_word;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  initial begin
    assert_grp_divides_depth_R6: assert (DEPTH % NGRP == 0 && DEPTH >= 2);
  end
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(out_data));
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    step |=> out_valid);
endmodule

// File: tb/tdl_top_tb_top.sv
module tdl_top_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int NGRP   = 4;
  localparam int GW     = DEPTH / NGRP;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int stepcnt = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] hist [4096];
  logic [DATA_W-1:0] last_out = '0;

  always #4 clk = ~clk;

  tdl_top #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NGRP(NGRP)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (step %0d)", req, act, exp, stepcnt);
    end
  endtask

  // one clock: drive at falling edge, sample just after the rising edge
  task automatic cyc(input bit v, input logic [DATA_W-1:0] d);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    @(posedge clk);
    #1;
    if (v) begin
      hist[stepcnt] = d;
      chk("R2 valid pulse", out_valid, 1);
      if (stepcnt >= DEPTH - 1)
        chk("R3 delayed word", out_data, hist[stepcnt - DEPTH + 1]);
      stepcnt++;
      last_out = out_data;
    end else begin
      chk("R2 no pulse when idle", out_valid, 0);
      chk("R4 output holds", out_data, last_out);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 ready low in reset", in_ready, 0);
    chk("R1 out_data cleared", out_data, 0);
    chk("R1 out_valid low", out_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    #1;
    chk("R9 ready high after reset", in_ready, 1);
    @(posedge clk);
    #1;
    chk("R1 out_data zero after reset", out_data, 0);
    chk("R1 out_valid low after reset", out_valid, 0);
    stepcnt = 0;
    last_out = '0;
  endtask

  task automatic t_contig_R7(input int laps);
    for (int i = 0; i < laps * DEPTH; i++) cyc(1'b1, DATA_W'(i * 7 + 3));
  endtask

  task automatic t_gaps_R8();
    for (int i = 0; i < 3 * DEPTH; i++) begin
      cyc(1'b0, DATA_W'(8'hEE ^ i));
      cyc(1'b0, DATA_W'(8'h5A + i));
      cyc(1'b1, DATA_W'(i * 13 + 1));
    end
  endtask

  task automatic t_boundary_R6();
    for (int i = 0; i < 3 * DEPTH; i++) begin
      if ((stepcnt % GW) == 0 || (stepcnt % GW) == GW - 1)
        for (int j = 0; j < 3; j++) cyc(1'b0, DATA_W'(8'hC3 + j));
      cyc(1'b1, DATA_W'(8'h80 ^ (i * 5)));
    end
  endtask

  initial begin
    t_reset();
    t_contig_R7(4);
    t_gaps_R8();
    t_boundary_R6();
    t_reset();
    t_contig_R7(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule